// File: doc/BRIEF.md
# Iterative Shift-and-Add Multiplier

This block multiplies two operands of configurable width, 32 bits by default, and returns a double-width product. The work is spread over many cycles. At the start, the magnitude of the multiplier goes into the low half of a single double-width product register, and the high half is cleared. On each following cycle the unit looks at the lowest bit of that register. If the bit is one, it adds the multiplicand magnitude into the high half, and in the same cycle it shifts the whole register right by one. The carry out of the addition moves into the top bit, so no product bits are lost. One adder of operand width does all the arithmetic.

A mode input picks unsigned or two's-complement operation. In signed mode the unit multiplies the operand magnitudes. In one extra cycle at the end it negates the double-width result when the operand signs differ. The product appears as a high word and a low word. A flag shows that the product does not fit in a single word. A caller raises `start_i` for one cycle while `busy_o` is low, then waits for the one-cycle `done_o` pulse. The result stays on the outputs until the next accepted start.

Top module: `seq_mul_unit`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `hi_o` and `lo_o` are zero and `ovf_o` is 0.
- R2: A start is accepted only on a clock edge where `start_i` is 1 and `busy_o` is 0. `busy_o` is 1 in the cycle that follows that edge.
- R3: `done_o` is 1 for exactly one cycle, which begins WIDTH+1 clock edges after the accepting edge (WIDTH step cycles plus one sign fix-up cycle). `busy_o` falls in the same cycle.
- R4: In unsigned mode (`signed_i`=0 at the accepting edge), {`hi_o`,`lo_o`} equals the full 2*WIDTH-bit unsigned product. Carries out of the top bit of the adder are kept, so all-ones operands give the exact result.
- R5: In signed mode (`signed_i`=1 at the accepting edge), {`hi_o`,`lo_o`} equals the 2*WIDTH-bit two's-complement product. This includes operands equal to the most negative value.
- R6: `hi_o` carries bits 2*WIDTH-1..WIDTH of the product and `lo_o` carries bits WIDTH-1..0.
- R7: In unsigned mode, `ovf_o` is 1 exactly when `hi_o` is nonzero.
- R8: In signed mode, `ovf_o` is 1 exactly when `hi_o` differs from WIDTH copies of bit WIDTH-1 of `lo_o`.
- R9: A start pulse while `busy_o` is 1 has no effect. The running operation's result and timing do not change.
- R10: While `busy_o` is 0 and no start is accepted, `hi_o`, `lo_o` and `ovf_o` hold their values.
- R11: Operands and the mode are sampled only at the accepting edge. Changing them during the operation does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | WIDTH | Upper word of the product |
| lo_o | output | WIDTH | Lower word of the product |
| ovf_o | output | 1 | Product does not fit in one word |

## Verification
The assertions assume that `start_i` and `signed_i` are driven to known values on every clock edge. The checker records the mode itself at the accepting edge, so the overflow properties depend only on that captured mode and not on a `signed_i` that keeps changing. The bench drives inputs at the falling edge. It pulses `start_i` for one cycle when idle, and it raises it again during a run only to exercise the ignore rule, changing the operands and the mode at the same time. It sweeps every operand pair in both modes at a width of four bits.

// File: rtl/mul_unit_pkg.sv
package mul_unit_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STEP = 2'd1,
      ST_FIX  = 2'd2
   } mul_state_e;
endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep #(
   parameter int WIDTH        = 32,
   parameter bit SIGN_SUPPORT = 1'b1
) (
   input  logic [WIDTH-1:0] mcand_i,
   input  logic [WIDTH-1:0] mplier_i,
   input  logic             signed_i,
   output logic [WIDTH-1:0] mcand_mag_o,
   output logic [WIDTH-1:0] mplier_mag_o,
   output logic             negate_o
);
   generate
      if (SIGN_SUPPORT) begin : g_signed
         logic a_neg, b_neg;
         assign a_neg = signed_i & mcand_i[WIDTH-1];
         assign b_neg = signed_i & mplier_i[WIDTH-1];
         // magnitude of the most negative value wraps to itself, read unsigned
         assign mcand_mag_o  = a_neg ? (~mcand_i + 1'b1)  : mcand_i;
         assign mplier_mag_o = b_neg ? (~mplier_i + 1'b1) : mplier_i;
         assign negate_o     = a_neg ^ b_neg;
      end else begin : g_unsigned
         assign mcand_mag_o  = mcand_i;
         assign mplier_mag_o = mplier_i;
         assign negate_o     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl
   import mul_unit_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o,
   output logic load_o,
   output logic step_o,
   output logic fix_o
);
   localparam int CW = $clog2(WIDTH + 1);
   localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

   mul_state_e      state_q, state_d;
   logic [CW-1:0]   cnt_q;
   logic            done_q;

   assign load_o = (state_q == ST_IDLE) & start_i;
   assign step_o = (state_q == ST_STEP);
   assign fix_o  = (state_q == ST_FIX);
   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i) state_d = ST_STEP;
         ST_STEP: if (cnt_q == LAST_STEP) state_d = ST_FIX;
         ST_FIX:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= fix_o;
         if (load_o)      cnt_q <= '0;
         else if (step_o) cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mul_step_dp.sv
module mul_step_dp #(
   parameter int WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               step_i,
   input  logic               fix_i,
   input  logic               negate_i,
   input  logic [WIDTH-1:0]   mcand_mag_i,
   input  logic [WIDTH-1:0]   mplier_mag_i,
   output logic [2*WIDTH-1:0] prod_o
);
   localparam int PW = 2 * WIDTH;

   logic [WIDTH-1:0] mcand_q;
   logic [PW-1:0]    prod_q;
   logic [WIDTH:0]   sum;
   logic [PW-1:0]    shifted;

   // one adder of operand width; its carry becomes the new top bit
   assign sum     = {1'b0, prod_q[PW-1:WIDTH]} + {1'b0, mcand_q};
   assign shifted = prod_q[0] ? {sum, prod_q[WIDTH-1:1]}
                              : {1'b0, prod_q[PW-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         prod_q  <= '0;
      end else if (load_i) begin
         mcand_q <= mcand_mag_i;
         prod_q  <= {{WIDTH{1'b0}}, mplier_mag_i};
      end else if (step_i) begin
         prod_q  <= shifted;
      end else if (fix_i && negate_i) begin
         prod_q  <= '0 - prod_q;
      end
   end

   assign prod_o = prod_q;
endmodule

// File: rtl/mul_ovf_detect.sv
module mul_ovf_detect #(
   parameter int WIDTH        = 32,
   parameter bit SIGN_SUPPORT = 1'b1
) (
   input  logic [WIDTH-1:0] hi_i,
   input  logic [WIDTH-1:0] lo_i,
   input  logic             signed_i,
   output logic             ovf_o
);
   generate
      if (SIGN_SUPPORT) begin : g_both
         logic [WIDTH-1:0] ext;
         assign ext   = signed_i ? {WIDTH{lo_i[WIDTH-1]}} : '0;
         assign ovf_o = (hi_i != ext);
      end else begin : g_uns
         logic unused_lo;
         assign unused_lo = ^{lo_i, signed_i};
         assign ovf_o     = |hi_i;
      end
   endgenerate
endmodule

// File: rtl/seq_mul_unit.sv
module seq_mul_unit #(
   parameter int WIDTH        = 32,
   parameter bit SIGN_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             signed_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  logic [WIDTH-1:0] mplier_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] hi_o,
   output logic [WIDTH-1:0] lo_o,
   output logic             ovf_o
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seq_mul_unit: WIDTH must be at least 2");
      end
   endgenerate

   logic             load, step, fix;
   logic [WIDTH-1:0] mcand_mag, mplier_mag;
   logic             neg_now;
   logic             neg_q, mode_q;
   logic [2*WIDTH-1:0] prod;

   mul_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .busy_o(busy_o), .done_o(done_o),
      .load_o(load), .step_o(step), .fix_o(fix)
   );

   mul_operand_prep #(.WIDTH(WIDTH), .SIGN_SUPPORT(SIGN_SUPPORT)) u_prep (
      .mcand_i(mcand_i), .mplier_i(mplier_i), .signed_i(signed_i),
      .mcand_mag_o(mcand_mag), .mplier_mag_o(mplier_mag), .negate_o(neg_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         neg_q  <= 1'b0;
         mode_q <= 1'b0;
      end else if (load) begin
         neg_q  <= neg_now;
         mode_q <= signed_i;
      end
   end

   mul_step_dp #(.WIDTH(WIDTH)) u_dp (
      .clk(clk), .rst_n(rst_n),
      .load_i(load), .step_i(step), .fix_i(fix), .negate_i(neg_q),
      .mcand_mag_i(mcand_mag), .mplier_mag_i(mplier_mag),
      .prod_o(prod)
   );

   assign hi_o = prod[2*WIDTH-1:WIDTH];
   assign lo_o = prod[WIDTH-1:0];

   mul_ovf_detect #(.WIDTH(WIDTH), .SIGN_SUPPORT(SIGN_SUPPORT)) u_ovf (
      .hi_i(hi_o), .lo_i(lo_o), .signed_i(mode_q), .ovf_o(ovf_o)
   );
endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             signed_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [WIDTH-1:0] hi_o,
   input logic [WIDTH-1:0] lo_o,
   input logic             ovf_o
);
   logic        accept;
   logic [15:0] lat_q;
   logic        mode_q;

   assign accept = start_i & ~busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q  <= '0;
         mode_q <= 1'b0;
      end else if (accept) begin
         lat_q  <= '0;
         mode_q <= signed_i;
      end else if (busy_o) begin
         lat_q  <= lat_q + 1'b1;
      end
   end

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy_o); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R3
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o); // R3
   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (lat_q == 16'(WIDTH + 1))); // R3
   AST_OVF_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !mode_q) |-> (ovf_o == (hi_o != '0))); // R7
   AST_OVF_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mode_q) |-> (ovf_o == (hi_o != {WIDTH{lo_o[WIDTH-1]}}))); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(hi_o) && $stable(lo_o) && $stable(ovf_o))); // R10
endmodule

bind seq_mul_unit mul_unit_chk #(.WIDTH(WIDTH)) u_mul_unit_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
   .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o), .ovf_o(ovf_o)
);

// File: tb/test_seq_mul_unit.sv
module test_seq_mul_unit;
   localparam int W  = 4;
   localparam int PW = 2 * W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         signed_i = 1'b0;
   logic [W-1:0] mcand_i = '0;
   logic [W-1:0] mplier_i = '0;
   logic         busy_o, done_o, ovf_o;
   logic [W-1:0] hi_o, lo_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   seq_mul_unit #(.WIDTH(W)) i_seq_mul_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
      .mcand_i(mcand_i), .mplier_i(mplier_i),
      .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o), .ovf_o(ovf_o)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_op(input int a, input int b, input bit sgn, input bit poke);
      longint sa, sb, p;
      logic [PW-1:0] pbits;
      bit exp_ovf;
      int k;
      @(negedge clk);
      mcand_i = W'(a); mplier_i = W'(b); signed_i = sgn; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R2 busy after accept", longint'(busy_o), 1);
      k = 0;
      while (!done_o && k < 50) begin
         if (poke && k == 1) begin   // R9 R11: new start and changed inputs mid-run
            start_i = 1'b1; signed_i = ~sgn;
            mcand_i = ~W'(a); mplier_i = W'(b + 3);
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         k++;
      end
      start_i = 1'b0;
      chk("R3 latency", k, W + 1);
      chk("R3 busy low at done", longint'(busy_o), 0);
      sa = sgn && a >= (1 << (W - 1)) ? a - (1 << W) : a;
      sb = sgn && b >= (1 << (W - 1)) ? b - (1 << W) : b;
      p = sa * sb;
      pbits = PW'(p);
      if (sgn) exp_ovf = (p < -(1 << (W - 1))) || (p > (1 << (W - 1)) - 1);
      else     exp_ovf = (p > (1 << W) - 1);
      if (sgn) begin
         chk("R5 R6 hi word signed", longint'(hi_o), longint'(pbits[PW-1:W]));
         chk("R5 R6 lo word signed", longint'(lo_o), longint'(pbits[W-1:0]));
         chk("R8 signed overflow", longint'(ovf_o), longint'(exp_ovf));
      end else begin
         chk("R4 R6 hi word unsigned", longint'(hi_o), longint'(pbits[PW-1:W]));
         chk("R4 R6 lo word unsigned", longint'(lo_o), longint'(pbits[W-1:0]));
         chk("R7 unsigned overflow", longint'(ovf_o), longint'(exp_ovf));
      end
      mcand_i = W'(a + 5); mplier_i = W'(b + 7);
      @(negedge clk);
      chk("R3 done one cycle", longint'(done_o), 0);
      chk("R10 hold hi", longint'(hi_o), longint'(pbits[PW-1:W]));
      chk("R10 hold lo", longint'(lo_o), longint'(pbits[W-1:0]));
      chk("R10 hold ovf", longint'(ovf_o), longint'(exp_ovf));
   endtask

   initial begin
      #1;
      chk("R1 reset busy", longint'(busy_o), 0);
      chk("R1 reset done", longint'(done_o), 0);
      chk("R1 reset hi", longint'(hi_o), 0);
      chk("R1 reset lo", longint'(lo_o), 0);
      chk("R1 reset ovf", longint'(ovf_o), 0);
      #20 rst_n = 1'b1;
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
               run_op(a, b, bit'(s), ((a + b) % 5) == 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1500000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule